// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a ring of transmit descriptors held in system memory. A pulse on the start input makes it read the descriptor at its current pointer. If software has handed that descriptor to the engine, the block fetches the buffer it points to and sends the bytes out on a byte stream. It then returns the descriptor to software and moves on to the next entry. The walk ends at the first descriptor that software still owns. The pointer stays on that entry, so the next start pulse resumes from there.

Several descriptors can form one frame. Their bytes are joined in ring order until a descriptor marked as the end of a frame is consumed, and the final byte of the frame carries the stream's last flag. A frame is cut off at a fixed maximum size and an overflow event reports the cut. Three single-cycle event outputs report each consumed descriptor, each completed frame and each overflow. A separate block normally counts or masks these events into an interrupt.

The memory side is one word-wide port with a request/grant handshake. Each granted request, read or write, gets exactly one response strobe a fixed number of cycles later. The ring base and a load strobe set the walk pointer, and the current pointer is visible at all times.

Top module: `txr_engine`

## Requirements
- R1: After reset the block is idle (`busy_o` low). It makes no memory request, drives no stream byte and raises no event, and `cur_ptr_o` is zero.
- R2: A descriptor is two 32-bit little-endian words. Word 0 holds the byte length in bits 15:0 and the control flags in bits 31:16. Word 1 holds the buffer byte address. Within the flags, bit 15 (word bit 31) means owned by the engine, bit 13 (word bit 29) means wrap, and bit 11 (word bit 27) means end of frame.
- R3: The walk stops at the first descriptor whose ownership bit is clear. That descriptor is not written, and `cur_ptr_o` is left pointing at it.
- R4: After a descriptor is consumed, the pointer advances by 8. If the wrap bit is set, the pointer instead returns to `ring_base_i`.
- R5: Each consumed descriptor has word 0 written back with only bit 31 cleared. One `ev_buf_done_o` pulse follows that write.
- R6: Buffer bytes leave in ascending address order, taken from little-endian words, from any byte-aligned start address. Buffers are joined until an end-of-frame descriptor. `tx_last_o` marks the frame's final byte, and each end-of-frame descriptor gives one `ev_frame_done_o` pulse. A frame with no bytes emits nothing but still completes.
- R7: A frame carries at most 2032 bytes. Bytes of a buffer beyond that limit are dropped, and every descriptor whose length would pass the limit gives one `ev_babble_o` pulse. The byte count restarts at each end of frame.
- R8: A start pulse that arrives during a walk is remembered, and a fresh walk from the current pointer follows once the running walk stops.
- R9: `base_load_i` copies `ring_base_i` into the pointer only while idle. While a walk runs, it has no effect.
- R10: At most one memory request is outstanding. A request and its address stay constant until granted.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, the stream byte and last flag hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick_i | input | 1 | Start pulse for a ring walk |
| base_load_i | input | 1 | Load pointer from ring base (idle only) |
| ring_base_i | input | 32 | Ring base byte address |
| cur_ptr_o | output | 32 | Current descriptor pointer |
| busy_o | output | 1 | Walk in progress or pending |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Response strobe |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream sink ready |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of frame |
| ev_buf_done_o | output | 1 | Descriptor consumed pulse |
| ev_frame_done_o | output | 1 | Frame completed pulse |
| ev_babble_o | output | 1 | Frame length overflow pulse |

## Verification
The bound checker watches the memory handshake on every cycle: it allows one outstanding request and holds each request until it is granted. It also checks that the stream holds under backpressure, that no frame passes 2032 bytes, and that every descriptor-done pulse comes right after a write response. Byte order, unaligned starts, frame joining, wrap to the base, stopping at a software-owned entry, the remembered restart and the ignored pointer load are shown only by the bench scenarios. There, a behavioural ring model predicts the byte stream, the event counts, the written-back descriptors and the final pointer, under random grant delays and stream stalls.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int WORD_W     = 32;
  localparam int LEN_W      = 16;
  localparam int DESC_BYTES = 8;
  // flag positions inside the 16-bit control half of word 0
  localparam int FLG_OWN    = 15;
  localparam int FLG_WRAP   = 13;
  localparam int FLG_EOF    = 11;

  typedef enum logic [3:0] {
    W_IDLE,
    W_HDR_REQ,
    W_HDR_WAIT,
    W_PTR_REQ,
    W_PTR_WAIT,
    W_DAT_REQ,
    W_DAT_WAIT,
    W_EMIT,
    W_EOF,
    W_WB_REQ,
    W_WB_WAIT
  } walk_st_t;
endpackage

// File: rtl/txr_cap.sv
module txr_cap #(
  parameter int MAX_FRAME = 2032,
  parameter int LEN_W     = 16,
  localparam int CNT_W    = $clog2(MAX_FRAME + 1)
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [LEN_W-1:0] take_o,
  output logic             over_o
);
  logic [LEN_W:0] room;

  always_comb begin
    room   = (LEN_W+1)'(MAX_FRAME) - (LEN_W+1)'(cnt_i);
    over_o = {1'b0, len_i} > room;
    take_o = over_o ? room[LEN_W-1:0] : len_i;
  end
endmodule

// File: rtl/txr_holdout.sv
module txr_holdout #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  input  logic              eof_req_i,
  output logic              eof_ack_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_last_o
);
  logic              hold_v_q, hold_v_d;
  logic [BYTE_W-1:0] hold_d_q, hold_d_d;
  logic              out_v_q, out_v_d;
  logic [BYTE_W-1:0] out_d_q, out_d_d;
  logic              out_l_q, out_l_d;
  logic              out_free;

  always_comb begin
    out_free   = !out_v_q || tx_ready_i;
    in_ready_o = !hold_v_q || out_free;
    eof_ack_o  = !hold_v_q || out_free;

    hold_v_d = hold_v_q;
    hold_d_d = hold_d_q;
    out_v_d  = out_v_q && !tx_ready_i;
    out_d_d  = out_d_q;
    out_l_d  = out_l_q;

    if (in_valid_i && in_ready_o) begin
      // a newer byte proves the held one is not the frame's final byte
      if (hold_v_q) begin
        out_v_d = 1'b1;
        out_d_d = hold_d_q;
        out_l_d = 1'b0;
      end
      hold_v_d = 1'b1;
      hold_d_d = in_data_i;
    end else if (eof_req_i && hold_v_q && out_free) begin
      out_v_d  = 1'b1;
      out_d_d  = hold_d_q;
      out_l_d  = 1'b1;
      hold_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_d_q <= '0;
      out_v_q  <= 1'b0;
      out_d_q  <= '0;
      out_l_q  <= 1'b0;
    end else begin
      hold_v_q <= hold_v_d;
      hold_d_q <= hold_d_d;
      out_v_q  <= out_v_d;
      out_d_q  <= out_d_d;
      out_l_q  <= out_l_d;
    end
  end

  assign tx_valid_o = out_v_q;
  assign tx_data_o  = out_d_q;
  assign tx_last_o  = out_l_q;
endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_FRAME = 2032,
  localparam int CNT_W    = $clog2(MAX_FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick_i,
  input  logic              base_load_i,
  input  logic [AW-1:0]     ring_base_i,
  output logic [AW-1:0]     cur_ptr_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [LEN_W-1:0]  cap_len_o,
  output logic [CNT_W-1:0]  cap_cnt_o,
  input  logic [LEN_W-1:0]  cap_take_i,
  input  logic              cap_over_i,
  output logic              byte_valid_o,
  output logic [7:0]        byte_data_o,
  input  logic              byte_ready_i,
  output logic              eof_req_o,
  input  logic              eof_ack_i,
  output logic              ev_buf_o,
  output logic              ev_frm_o,
  output logic              ev_bab_o
);
  localparam int LANE_W = $clog2(WORD_W / 8);

  walk_st_t          st_q, st_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic              pend_q, pend_d;
  logic [LEN_W-1:0]  dlen_q, dlen_d;
  logic [LEN_W-1:0]  dflg_q, dflg_d;
  logic [AW-1:0]     baddr_q, baddr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  fcnt_q, fcnt_d;
  logic              ev_buf_d, ev_frm_d, ev_bab_d;
  logic              ev_buf_q, ev_frm_q, ev_bab_q;
  logic [LANE_W-1:0] lane;
  logic              emit_hs;

  assign lane      = baddr_q[LANE_W-1:0];
  assign emit_hs   = (st_q == W_EMIT) && byte_ready_i;
  assign cap_len_o = dlen_q;
  assign cap_cnt_o = fcnt_q;

  always_comb begin
    st_d     = st_q;
    ptr_d    = ptr_q;
    pend_d   = pend_q | kick_i;
    dlen_d   = dlen_q;
    dflg_d   = dflg_q;
    baddr_d  = baddr_q;
    rem_d    = rem_q;
    word_d   = word_q;
    fcnt_d   = fcnt_q;
    ev_buf_d = 1'b0;
    ev_frm_d = 1'b0;
    ev_bab_d = 1'b0;

    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    mem_addr_o   = ptr_q;
    mem_wdata_o  = '0;
    byte_valid_o = 1'b0;
    eof_req_o    = 1'b0;

    unique case (st_q)
      W_IDLE: begin
        if (base_load_i) ptr_d = ring_base_i;
        if (pend_q || kick_i) begin
          pend_d = 1'b0;
          st_d   = W_HDR_REQ;
        end
      end
      W_HDR_REQ: begin
        mem_req_o = 1'b1;
        if (mem_gnt_i) st_d = W_HDR_WAIT;
      end
      W_HDR_WAIT: begin
        if (mem_rvalid_i) begin
          dlen_d = mem_rdata_i[LEN_W-1:0];
          dflg_d = mem_rdata_i[WORD_W-1:LEN_W];
          st_d   = mem_rdata_i[LEN_W+FLG_OWN] ? W_PTR_REQ : W_IDLE;
        end
      end
      W_PTR_REQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ptr_q + AW'(4);
        if (mem_gnt_i) st_d = W_PTR_WAIT;
      end
      W_PTR_WAIT: begin
        if (mem_rvalid_i) begin
          baddr_d  = mem_rdata_i[AW-1:0];
          rem_d    = cap_take_i;
          ev_bab_d = cap_over_i;
          if (cap_take_i != '0)   st_d = W_DAT_REQ;
          else if (dflg_q[FLG_EOF]) st_d = W_EOF;
          else                      st_d = W_WB_REQ;
        end
      end
      W_DAT_REQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {baddr_q[AW-1:LANE_W], {LANE_W{1'b0}}};
        if (mem_gnt_i) st_d = W_DAT_WAIT;
      end
      W_DAT_WAIT: begin
        if (mem_rvalid_i) begin
          word_d = mem_rdata_i;
          st_d   = W_EMIT;
        end
      end
      W_EMIT: begin
        byte_valid_o = 1'b1;
        if (emit_hs) begin
          baddr_d = baddr_q + AW'(1);
          rem_d   = rem_q - LEN_W'(1);
          fcnt_d  = fcnt_q + CNT_W'(1);
          if (rem_q == LEN_W'(1))       st_d = dflg_q[FLG_EOF] ? W_EOF : W_WB_REQ;
          else if (lane == '1)          st_d = W_DAT_REQ;
        end
      end
      W_EOF: begin
        eof_req_o = 1'b1;
        if (eof_ack_i) begin
          fcnt_d = '0;
          st_d   = W_WB_REQ;
        end
      end
      W_WB_REQ: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = {dflg_q & ~(LEN_W'(1) << FLG_OWN), dlen_q};
        if (mem_gnt_i) st_d = W_WB_WAIT;
      end
      W_WB_WAIT: begin
        if (mem_rvalid_i) begin
          ev_buf_d = 1'b1;
          ev_frm_d = dflg_q[FLG_EOF];
          ptr_d    = dflg_q[FLG_WRAP] ? ring_base_i : ptr_q + AW'(DESC_BYTES);
          st_d     = W_HDR_REQ;
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= W_IDLE;
      ptr_q    <= '0;
      pend_q   <= 1'b0;
      dlen_q   <= '0;
      dflg_q   <= '0;
      baddr_q  <= '0;
      rem_q    <= '0;
      word_q   <= '0;
      fcnt_q   <= '0;
      ev_buf_q <= 1'b0;
      ev_frm_q <= 1'b0;
      ev_bab_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      ptr_q    <= ptr_d;
      pend_q   <= pend_d;
      dlen_q   <= dlen_d;
      dflg_q   <= dflg_d;
      baddr_q  <= baddr_d;
      rem_q    <= rem_d;
      word_q   <= word_d;
      fcnt_q   <= fcnt_d;
      ev_buf_q <= ev_buf_d;
      ev_frm_q <= ev_frm_d;
      ev_bab_q <= ev_bab_d;
    end
  end

  assign byte_data_o = word_q[8*lane +: 8];
  assign cur_ptr_o   = ptr_q;
  assign busy_o      = (st_q != W_IDLE) || pend_q;
  assign ev_buf_o    = ev_buf_q;
  assign ev_frm_o    = ev_frm_q;
  assign ev_bab_o    = ev_bab_q;
endmodule

// File: rtl/txr_engine.sv
module txr_engine #(
  parameter int AW        = 32,
  parameter int MAX_FRAME = 2032
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick_i,
  input  logic          base_load_i,
  input  logic [AW-1:0] ring_base_i,
  output logic [AW-1:0] cur_ptr_o,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  output logic          ev_buf_done_o,
  output logic          ev_frame_done_o,
  output logic          ev_babble_o
);
  localparam int CNT_W = $clog2(MAX_FRAME + 1);
  localparam int LEN_W = txr_pkg::LEN_W;

  logic [LEN_W-1:0] cap_len, cap_take;
  logic [CNT_W-1:0] cap_cnt;
  logic             cap_over;
  logic             byte_valid, byte_ready, eof_req, eof_ack;
  logic [7:0]       byte_data;

  txr_walker #(.AW(AW), .MAX_FRAME(MAX_FRAME)) u_walk (
    .clk, .rst_n, .kick_i, .base_load_i, .ring_base_i, .cur_ptr_o, .busy_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .cap_len_o(cap_len), .cap_cnt_o(cap_cnt),
    .cap_take_i(cap_take), .cap_over_i(cap_over),
    .byte_valid_o(byte_valid), .byte_data_o(byte_data), .byte_ready_i(byte_ready),
    .eof_req_o(eof_req), .eof_ack_i(eof_ack),
    .ev_buf_o(ev_buf_done_o), .ev_frm_o(ev_frame_done_o), .ev_bab_o(ev_babble_o)
  );

  txr_cap #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W)) u_cap (
    .len_i(cap_len), .cnt_i(cap_cnt), .take_o(cap_take), .over_o(cap_over)
  );

  txr_holdout #(.BYTE_W(8)) u_hold (
    .clk, .rst_n,
    .in_valid_i(byte_valid), .in_data_i(byte_data), .in_ready_o(byte_ready),
    .eof_req_i(eof_req), .eof_ack_o(eof_ack),
    .tx_valid_o, .tx_ready_i, .tx_data_o, .tx_last_o
  );
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk #(
  parameter int MAX_FRAME = 2032
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_req_o,
  input logic       mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic       mem_gnt_i,
  input logic       mem_rvalid_i,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [7:0] tx_data_o,
  input logic       tx_last_o,
  input logic       ev_buf_done_o,
  input logic       ev_frame_done_o
);
  localparam int BC_W = $clog2(MAX_FRAME + 1) + 1;

  logic            outst_q, wr_q;
  logic [BC_W-1:0] bcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
      wr_q    <= 1'b0;
      bcnt_q  <= '0;
    end else begin
      if (mem_req_o && mem_gnt_i) begin
        outst_q <= 1'b1;
        wr_q    <= mem_we_o;
      end else if (mem_rvalid_i) begin
        outst_q <= 1'b0;
      end
      if (tx_valid_o && tx_ready_i)
        bcnt_q <= tx_last_o ? '0 : bcnt_q + BC_W'(1);
    end
  end

  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !mem_req_o);

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

  a_r7_frame_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && tx_ready_i) |-> (bcnt_q < BC_W'(MAX_FRAME)));

  a_r6_frame_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_done_o |-> ev_buf_done_o);

  a_r5_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buf_done_o |-> $past(mem_rvalid_i && wr_q));
endmodule

bind txr_engine txr_engine_chk #(.MAX_FRAME(MAX_FRAME)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
  .tx_data_o(tx_data_o), .tx_last_o(tx_last_o),
  .ev_buf_done_o(ev_buf_done_o), .ev_frame_done_o(ev_frame_done_o)
);

// File: tb/txr_engine_tb.sv
`timescale 1ns/1ps
module txr_engine_tb;
  localparam int MAXF = 2032;
  localparam int LAT  = 2;
  localparam int MW   = 4096;
  localparam int WD   = 150000;
  localparam logic [31:0] OWN = 32'h8000_0000, WRP = 32'h2000_0000, EOFB = 32'h0800_0000;
  localparam logic [31:0] R8ADDR = 32'h0000_0138;

  logic clk = 1'b0;
  logic rst_n, kick, load;
  logic [31:0] base;
  logic mem_gnt, mem_rvalid;
  logic [31:0] mem_rdata;
  logic tx_ready;
  logic [31:0] cur_ptr, mem_addr, mem_wdata;
  logic busy, mem_req, mem_we, tx_valid, tx_last, ev_buf, ev_frm, ev_bab;
  logic [7:0] tx_data;

  always #2.5 clk = ~clk;

  txr_engine #(.AW(32), .MAX_FRAME(MAXF)) u_dut (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .base_load_i(load), .ring_base_i(base),
    .cur_ptr_o(cur_ptr), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data), .tx_last_o(tx_last),
    .ev_buf_done_o(ev_buf), .ev_frame_done_o(ev_frm), .ev_babble_o(ev_bab)
  );

  logic [31:0] mem [0:MW-1];
  logic [31:0] mm  [0:MW-1];
  logic [7:0]  exp_d [$];
  bit          exp_l [$];
  int total, bad, cyc, rcnt;
  int n_buf, n_frm, n_bab, e_buf, e_frm, e_bab;
  int mfc, gnt_mode, rdy_mode;
  logic [31:0] mptr, mbase, rq, lfsr, r8_w0, r8_w1;
  bit timed_out, arm_r8;
  string tag;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] mm_byte(input logic [31:0] a);
    logic [31:0] w;
    w = mm[a[13:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  // behavioural ring model: walks mm from mptr until a software-owned entry
  task automatic model_walk();
    logic [31:0] w0, ba;
    int len, take;
    while (1) begin
      w0 = mm[mptr[13:2]];
      if (!w0[31]) break;
      len = int'(w0[15:0]);
      ba  = mm[mptr[13:2] + 1];
      take = len;
      if (mfc + len > MAXF) begin
        take = MAXF - mfc;
        e_bab++;
      end
      for (int i = 0; i < take; i++) begin
        exp_d.push_back(mm_byte(ba + 32'(i)));
        exp_l.push_back(1'b0);
      end
      mfc += take;
      if (w0[27]) begin
        if (mfc > 0) exp_l[exp_l.size()-1] = 1'b1;
        e_frm++;
        mfc = 0;
      end
      e_buf++;
      mm[mptr[13:2]] = w0 & ~OWN;
      mptr = w0[29] ? mbase : mptr + 32'd8;
    end
  endtask

  task automatic put_desc(input int idx, input logic [31:0] flags,
                          input int len, input logic [31:0] addr);
    logic [31:0] a;
    a = mbase + 32'(idx * 8);
    mem[a[13:2]]     = flags | 32'(len[15:0]);
    mem[a[13:2] + 1] = addr;
    mm[a[13:2]]      = flags | 32'(len[15:0]);
    mm[a[13:2] + 1]  = addr;
  endtask

  // memory, stream sink, event counters and watchdog, all at the falling edge
  initial begin
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0; tx_ready = 0;
    rcnt = 0; lfsr = 32'h1234_5678;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > WD) timed_out = 1;
      if (rst_n) begin
        if (ev_buf) n_buf++;
        if (ev_frm) n_frm++;
        if (ev_bab) n_bab++;
      end
      mem_rvalid = 0;
      if (rcnt > 0) begin
        rcnt--;
        if (rcnt == 0) begin
          mem_rvalid = 1;
          mem_rdata  = rq;
        end
      end
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      mem_gnt = 0;
      if (rst_n && mem_req && rcnt == 0 && !mem_rvalid && (gnt_mode == 0 || lfsr[20])) begin
        mem_gnt = 1;
        if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
        else begin
          rq = mem[mem_addr[13:2]];
          if (arm_r8 && mem_addr == R8ADDR) begin
            mem[R8ADDR[13:2]]     = r8_w0;
            mem[R8ADDR[13:2] + 1] = r8_w1;
            arm_r8 = 0;
          end
        end
        rcnt = LAT;
      end
      tx_ready = (rdy_mode == 0) ? 1'b1 : lfsr[23];
      if (rst_n && tx_valid && tx_ready) begin
        if (exp_d.size() == 0) check(0, tag, "unexpected stream byte", tx_data, 0);
        else begin
          logic [7:0] d;
          bit l;
          d = exp_d.pop_front();
          l = exp_l.pop_front();
          check(tx_data == d && tx_last == l, tag, "stream byte {last,data}",
                {tx_last, tx_data}, {l, d});
        end
      end
    end
  end

  task automatic pulse_kick();
    @(negedge clk); kick = 1;
    @(negedge clk); kick = 0;
  endtask

  task automatic wait_done();
    while (!busy && !timed_out) @(negedge clk);
    while ((busy || tx_valid || rcnt != 0) && !timed_out) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_check(input string ptr_req);
    int mism;
    mism = 0;
    check(cur_ptr == mptr, ptr_req, "pointer after walk", cur_ptr, mptr);
    check(n_buf == e_buf, "R5", "buffer-done pulses", n_buf, e_buf);
    check(n_frm == e_frm, "R6", "frame-done pulses", n_frm, e_frm);
    check(n_bab == e_bab, "R7", "overflow pulses", n_bab, e_bab);
    check(exp_d.size() == 0, "R6", "bytes still expected", exp_d.size(), 0);
    for (int i = 64; i < 128; i++) if (mem[i] != mm[i]) mism++;
    check(mism == 0, "R5", "descriptor write-back mismatches", mism, 0);
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0; timed_out = 0; arm_r8 = 0;
    n_buf = 0; n_frm = 0; n_bab = 0; e_buf = 0; e_frm = 0; e_bab = 0;
    mfc = 0; gnt_mode = 0; rdy_mode = 0; tag = "R6";
    rst_n = 0; kick = 0; load = 0; base = '0;
    for (int i = 0; i < MW; i++) begin
      logic [31:0] w;
      for (int b = 0; b < 4; b++) w[8*b +: 8] = 8'((i*4 + b) * 7 + ((i*4 + b) >> 8));
      mem[i] = (i >= 256) ? w : 32'h0;
      mm[i]  = mem[i];
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!busy, "R1", "busy after reset", busy, 0);
    check(!mem_req, "R1", "memory request after reset", mem_req, 0);
    check(!tx_valid, "R1", "stream valid after reset", tx_valid, 0);
    check(cur_ptr == 0, "R1", "pointer after reset", cur_ptr, 0);
    check(!(ev_buf || ev_frm || ev_bab), "R1", "events after reset", {ev_buf, ev_frm, ev_bab}, 0);

    // S2: single aligned descriptor (R2, R6), pointer loaded while idle (R9)
    mbase = 32'h100; mptr = mbase; base = mbase;
    @(negedge clk); load = 1;
    @(negedge clk); load = 0;
    check(cur_ptr == 32'h100, "R9", "pointer load while idle", cur_ptr, 32'h100);
    put_desc(0, OWN | EOFB, 10, 32'h400);
    tag = "R2";
    model_walk();
    pulse_kick(); wait_done(); finish_check("R2");

    // S3: joined buffers, unaligned starts, empty middle buffer, stalls (R3, R6, R11)
    gnt_mode = 1; rdy_mode = 1; tag = "R6";
    put_desc(1, OWN, 5, 32'h501);
    put_desc(2, OWN, 0, 32'h580);
    put_desc(3, OWN | EOFB, 7, 32'h603);
    model_walk();
    pulse_kick(); wait_done(); finish_check("R3");

    // S4: wrap back to the ring base (R4)
    tag = "R4";
    put_desc(4, OWN | EOFB | WRP, 6, 32'h700);
    put_desc(0, OWN | EOFB, 3, 32'h802);
    model_walk();
    pulse_kick(); wait_done(); finish_check("R4");

    // S5: frame cap and restart of the count (R7)
    tag = "R7"; rdy_mode = 0;
    put_desc(1, OWN, 1500, 32'h1000);
    put_desc(2, OWN | EOFB, 1000, 32'h2000);
    put_desc(3, OWN | EOFB, 4, 32'h3001);
    put_desc(4, 32'h0, 0, 32'h0);
    model_walk();
    pulse_kick(); wait_done(); finish_check("R7");

    // S6: end-of-frame descriptor with no bytes (R6)
    tag = "R6"; rdy_mode = 1;
    put_desc(4, OWN | EOFB, 0, 32'h900);
    model_walk();
    pulse_kick(); wait_done(); finish_check("R6");

    // S7: start pulse during a walk is remembered (R8); load while busy ignored (R9)
    tag = "R8";
    put_desc(5, OWN | EOFB, 8, 32'h900);
    put_desc(6, OWN | EOFB, 8, 32'h981);
    r8_w0 = OWN | EOFB | 32'd5; r8_w1 = 32'hA00;
    arm_r8 = 1;
    model_walk();
    mm[R8ADDR[13:2]] = r8_w0; mm[R8ADDR[13:2] + 1] = r8_w1;
    model_walk();
    pulse_kick();
    repeat (3) @(negedge clk);
    base = 32'h200;
    kick = 1; load = 1;
    @(negedge clk); kick = 0; load = 0;
    check(busy, "R8", "walk still running at second start", busy, 1);
    wait_done();
    finish_check("R9");
    check(cur_ptr == 32'h140, "R8", "rescan consumed late descriptor", cur_ptr, 32'h140);

    check(!timed_out, "R1", "watchdog expired", cyc, WD);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule